// File: doc/BRIEF.md
# Encode Clock Divider with Phase Offset

This block turns a fast encode clock into a one-cycle-wide divide strobe that downstream logic uses as a clock enable. The strobe period is selectable between one and eight input cycles. A separate phase field places the strobe at a chosen input cycle inside each period, so several parts that receive a common sync pulse can line up their divided clocks.

A three-bit ratio code N selects a period of N+1 input cycles. A three-bit phase code sets the position of the strobe inside the period. The period and position are captured when a sync pulse arrives and at the end of each period, never partway through one, so a new ratio never produces a shortened period. The block also drives a duty-cycle stabilizer enable. This output follows a request bit while the clock is undivided and is held on for any other ratio.

Top module: `encclk_divider`

## Requirements
- R1: While `rst` is high at a rising edge, `div_stb_o` and `dcs_en_o` are both 0 after that edge.
- R2: With ratio code N, the strobe is high for exactly one cycle out of every N+1 input cycles.
- R3: If `sync_i` is sampled high at edge K, then with phase code P below N+1 the strobe is first high in the cycle after edge K+1+P, and again every N+1 cycles after that.
- R4: A phase code P of N+1 or more acts as P modulo (N+1).
- R5: With ratio code 0 (divide by 1), the strobe is high in every cycle whatever the phase code.
- R6: A change of the ratio code takes effect only at the end of the current period. The period in progress completes at its old length, and a new period of the new length starts on the edge after it.
- R7: `dcs_en_o` equals `dcs_req_i` while the active ratio is divide by 1, and is 1 for every other active ratio. It is registered and lags the active ratio by one cycle.
- R8: A sync pulse sampled in the middle of a period restarts the count at once. This loads the current ratio and phase codes, and the strobe timing of R3 is measured from the new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast encode clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | RATIO_W | Ratio code N, giving divide by N+1 |
| phase_sel | input | PHASE_W | Strobe offset in input cycles |
| sync_i | input | 1 | Alignment pulse that restarts the count |
| dcs_req_i | input | 1 | Stabilizer enable requested by configuration |
| div_stb_o | output | 1 | Divided clock strobe, one cycle wide |
| dcs_en_o | output | 1 | Effective stabilizer enable |

## Verification
The bench builds the block with its default widths of three bits for both codes. At these widths every ratio from 1 to 8 can be reached, along with phase codes larger than the period, which exercises the modulo wrap. The scoreboard predicts the strobe and the stabilizer enable cycle by cycle from each sync pulse. It covers ratio changes made mid-period, where both the old and the new period lengths appear in one run, and back-to-back sync pulses that cut a period short.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Reduce a phase code into the range of the active period length.
  function automatic int unsigned wrap_phase(input int unsigned p, input int unsigned len);
    if (len == 0) return 0;
    return p % len;
  endfunction

endpackage

// File: rtl/clkdiv_cfg_latch.sv
module clkdiv_cfg_latch
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 3,
  parameter int PHASE_W = 3,
  localparam int DIV_W  = RATIO_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic [DIV_W-1:0]   len_o,
  output logic [DIV_W-1:0]   tgt_o
);

  logic [DIV_W-1:0] len_next;
  logic [DIV_W-1:0] tgt_next;

  always_comb begin
    len_next = DIV_W'(ratio_i) + DIV_W'(1);
    tgt_next = DIV_W'(wrap_phase(int'(phase_i), int'(len_next)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_o <= DIV_W'(1);
      tgt_o <= '0;
    end else if (load_i) begin
      len_o <= len_next;
      tgt_o <= tgt_next;
    end
  end

  // R4
  tgt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_o < len_o);

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic [DIV_W-1:0] len_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic             wrap_o
);

  assign wrap_o = (cnt_o == len_i - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || sync_i || wrap_o) cnt_o <= '0;
    else                         cnt_o <= cnt_o + DIV_W'(1);
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_o < len_i);

endmodule

// File: rtl/clkdiv_outputs.sv
module clkdiv_outputs #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cnt_i,
  input  logic [DIV_W-1:0] tgt_i,
  input  logic [DIV_W-1:0] len_i,
  input  logic             dcs_req_i,
  output logic             stb_o,
  output logic             dcs_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_o <= 1'b0;
      dcs_o <= 1'b0;
    end else begin
      stb_o <= (cnt_i == tgt_i);
      dcs_o <= dcs_req_i | (len_i != DIV_W'(1));
    end
  end

endmodule

// File: rtl/encclk_divider.sv
module encclk_divider #(
  parameter int RATIO_W = 3,
  parameter int PHASE_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_sel,
  input  logic [PHASE_W-1:0] phase_sel,
  input  logic               sync_i,
  input  logic               dcs_req_i,
  output logic               div_stb_o,
  output logic               dcs_en_o
);

  localparam int DIV_W = RATIO_W + 1;

  logic [DIV_W-1:0] len;
  logic [DIV_W-1:0] tgt;
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  clkdiv_cfg_latch #(.RATIO_W(RATIO_W), .PHASE_W(PHASE_W)) u_cfg (
    .clk(clk), .rst(rst), .load_i(sync_i | wrap),
    .ratio_i(ratio_sel), .phase_i(phase_sel),
    .len_o(len), .tgt_o(tgt)
  );

  clkdiv_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk(clk), .rst(rst), .sync_i(sync_i), .len_i(len),
    .cnt_o(cnt), .wrap_o(wrap)
  );

  clkdiv_outputs #(.DIV_W(DIV_W)) u_out (
    .clk(clk), .rst(rst), .cnt_i(cnt), .tgt_i(tgt), .len_i(len),
    .dcs_req_i(dcs_req_i), .stb_o(div_stb_o), .dcs_o(dcs_en_o)
  );

  // R5
  div1_every_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (len == DIV_W'(1)) |=> div_stb_o);

  // R6
  len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync_i && !wrap) |=> $stable(len));

  // R7
  dcs_force_chk: assert property (@(posedge clk) disable iff (rst)
    (len != DIV_W'(1)) |=> dcs_en_o);

  // R8
  sync_restart_chk: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> (cnt == '0));

endmodule

// File: tb/sim_encclk_divider.sv
module sim_encclk_divider;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] ratio_sel = '0;
  logic [2:0] phase_sel = '0;
  logic       sync_i = 1'b0;
  logic       dcs_req_i = 1'b0;
  logic       div_stb_o;
  logic       dcs_en_o;

  encclk_divider u0 (
    .clk(clk), .rst(rst), .ratio_sel(ratio_sel), .phase_sel(phase_sel),
    .sync_i(sync_i), .dcs_req_i(dcs_req_i),
    .div_stb_o(div_stb_o), .dcs_en_o(dcs_en_o)
  );

  always #10ns clk = ~clk;

  typedef struct {
    int    cyc;
    bit    stb;
    bit    dcs;
    bit    chk_dcs;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare the head of the queue when its cycle comes up.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].cyc == cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (div_stb_o !== e.stb) begin
        n_bad++;
        $display("FAIL %s cyc=%0d strobe act=%b exp=%b", e.req, cyc, div_stb_o, e.stb);
      end
      if (e.chk_dcs) begin
        n_chk++;
        if (dcs_en_o !== e.dcs) begin
          n_bad++;
          $display("FAIL R7 cyc=%0d dcs act=%b exp=%b", cyc, dcs_en_o, e.dcs);
        end
      end
    end
  end

  function automatic bit exp_stb(int j, int d1, int d2, int p);
    if (j <= d1) return ((j - 1) == (p % d1));
    return (((j - 1 - d1) % d2) == (p % d2));
  endfunction

  // Driver: sync with ratio r1, switch the input to r2 right after the pulse.
  task automatic run_case(int r1, int r2, int p, bit dreq, int n, string req);
    int k;
    int d1;
    int d2;
    d1 = r1 + 1;
    d2 = r2 + 1;
    @(negedge clk);
    ratio_sel = 3'(r1);
    phase_sel = 3'(p);
    dcs_req_i = dreq;
    sync_i    = 1'b1;
    k = cyc + 1;
    for (int j = 1; j <= n; j++) begin
      exp_t e;
      e.cyc     = k + j;
      e.stb     = exp_stb(j, d1, d2, p);
      e.chk_dcs = (j >= 2);
      e.dcs     = (j <= d1) ? (dreq | (r1 != 0)) : (dreq | (r2 != 0));
      e.req     = req;
      q.push_back(e);
    end
    @(negedge clk);
    sync_i    = 1'b0;
    ratio_sel = 3'(r2);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (div_stb_o !== 1'b0 || dcs_en_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 act=%b%b exp=00", div_stb_o, dcs_en_o);
    end
    rst = 1'b0;

    run_case(3, 3, 0, 1'b0, 16, "R2");   // divide by 4
    run_case(7, 7, 0, 1'b0, 24, "R2");   // divide by 8
    run_case(4, 4, 3, 1'b0, 20, "R3");   // divide by 5, offset 3
    run_case(7, 7, 7, 1'b1, 24, "R3");   // divide by 8, last slot
    run_case(2, 2, 5, 1'b0, 15, "R4");   // 5 mod 3 = 2
    run_case(1, 1, 6, 1'b0, 10, "R4");   // 6 mod 2 = 0
    run_case(0, 0, 5, 1'b0, 8,  "R5");   // every cycle, phase ignored
    run_case(0, 0, 0, 1'b1, 6,  "R7");   // request followed at divide by 1
    run_case(3, 1, 0, 1'b0, 14, "R6");   // 4 then 2
    run_case(1, 5, 1, 1'b0, 16, "R6");   // 2 then 6
    run_case(5, 0, 2, 1'b0, 12, "R6");   // 6 then 1, stabilizer releases
    run_case(5, 5, 0, 1'b0, 3,  "R8");   // cut short mid-period
    run_case(2, 2, 1, 1'b0, 9,  "R8");   // realigned by fresh pulse

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule